// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Sequencer

This block raises a message to an exponent modulo an odd modulus, producing M^E mod N. It keeps all intermediate values in the Montgomery domain and uses one iterative radix-2 Montgomery multiplier for every step. The caller supplies the message, the exponent, the modulus and a precomputed conversion constant K. K is 2^(2(KW+2)) mod N, because the multiplier runs KW+2 iterations and so works with the radix R = 2^(KW+2).

A job starts with a one-cycle pulse on `start`. The block latches all operands and then runs the following steps in order:

- It converts the message into Montgomery form and stores it in the P register.
- It forms the Montgomery form of one in the Q register.
- It walks the exponent from its top bit down to bit 0. For each bit it squares Q, and when the bit is set it then multiplies Q by P.
- A final multiply by one takes Q out of the Montgomery domain.
- A single conditional subtraction brings the result below N.

`busy` covers the job, and `done` pulses for one cycle when the result is presented.

Top module: `modexp_mont`

## Requirements
- R1: For odd N > 1, M < N and K = 2^(2(KW+2)) mod N, the value on `result` while `done` is high equals M^E mod N, with the exponent scanned from bit KE-1 down to bit 0.
- R2: An exponent of zero gives a result of 1, for any M < N.
- R3: Whenever `done` is high, `result` is strictly less than the latched modulus.
- R4: `busy` is high from the cycle after a `start` pulse in the idle state until the job completes. `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R5: A `start` pulse while `busy` is high is ignored. The running job keeps its latched operands, and its result is unchanged.
- R6: A message of 0 with a nonzero exponent gives 0. A message of 1 gives 1 for any exponent.
- R7: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; operands are latched when idle |
| msg | input | KW | Message M, below N |
| expo | input | KE | Exponent E |
| modulus | input | KW | Odd modulus N greater than 1 |
| rconst | input | KW | Conversion constant 2^(2(KW+2)) mod N |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse with a valid result |
| result | output | KW | M^E mod N, held until the next job ends |

## Verification
The assertions assume the following about the inputs: the modulus is odd, it is larger than the message and the constant, and the constant is correct for that modulus. Only under these conditions does each multiplier output stay below twice the modulus, which in turn makes the final single subtraction enough. The stimulus draws moduli as random odd values of at least 3. It reduces each message modulo N and computes the constant in the bench by doubling modulo N, so every job stays inside these bounds. Corner exponents (zero and all ones) and corner messages (0 and 1) are checked, along with a second start issued in the middle of a job.

// File: rtl/modexp_pkg.sv
// Shared types for the modular exponentiation sequencer.
package modexp_pkg;

    // Sequencer phases; each non-idle phase owns one Montgomery multiply.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TO_P  = 3'd1,
        ST_TO_Q  = 3'd2,
        ST_SQR   = 3'd3,
        ST_MUL   = 3'd4,
        ST_BACK  = 3'd5
    } mx_state_e;

endpackage

// File: rtl/mont_mul_r2.sv
// Iterative radix-2 Montgomery multiplier.
// Computes S = A*B*2^-(W+2) mod N, returned in [0, 2N).
// Assumes: N odd, N < 2^W, A < 2N, B < 2N. Needs W+2 iterations after start.
// The quotient bit is picked from two precomputed candidates by the scanned A bit.
module mont_mul_r2 #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W:0]     a_i,
    input  logic [W:0]     b_i,
    input  logic [W-1:0]   n_i,
    output logic           done_o,
    output logic [W:0]     res_o
);
    localparam int OPW  = W + 1;
    localparam int SW   = W + 2;
    localparam int AW   = W + 3;
    localparam int ITER = W + 2;
    localparam int CW   = $clog2(ITER + 1);

    logic [SW-1:0]   s_q;
    logic [ITER-1:0] a_sh;
    logic [OPW-1:0]  b_q;
    logic [W-1:0]    n_q;
    logic [CW-1:0]   cnt_q;
    logic            run_q;
    logic            done_q;

    logic            a_bit, q_even, q_odd, q_sel;
    logic [AW-1:0]   add_b, add_n, sum;
    logic [SW-1:0]   s_next;

    // Quotient candidates and the shifted carry-propagate sum for one iteration.
    always_comb begin
        a_bit  = a_sh[0];
        q_even = s_q[0];
        q_odd  = s_q[0] ^ b_q[0];
        q_sel  = a_bit ? q_odd : q_even;
        add_b  = a_bit ? {2'b00, b_q} : '0;
        add_n  = q_sel ? {3'b000, n_q} : '0;
        sum    = {1'b0, s_q} + add_b + add_n;
        s_next = sum[AW-1:1];
    end

    // Operand capture on start, then one iteration per cycle until the count ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q    <= '0;
            a_sh   <= '0;
            b_q    <= '0;
            n_q    <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                s_q   <= '0;
                a_sh  <= {1'b0, a_i};
                b_q   <= b_i;
                n_q   <= n_i;
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                s_q   <= s_next;
                a_sh  <= a_sh >> 1;
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(ITER - 1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign res_o  = s_q[OPW-1:0];

    // R3: every product handed back stays below 2N, so one final subtraction suffices.
    a_r3_product_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (s_q < {1'b0, n_q, 1'b0}));

    // R4: completion is a single-cycle pulse.
    a_r4_mm_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/modexp_seq.sv
// Sequencer for left-to-right square-and-multiply.
// Launches one multiply per phase and advances on the multiplier's done pulse.
// Assumes the multiplier is idle whenever a launch is issued.
module modexp_seq
    import modexp_pkg::*;
#(
    parameter int KE = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [KE-1:0] expo_i,
    input  logic          mm_done_i,
    output mx_state_e     state_o,
    output logic          mm_start_o,
    output logic          latch_o,
    output logic          load_p_o,
    output logic          load_q_o,
    output logic          load_res_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam int IW = (KE > 1) ? $clog2(KE) : 1;

    mx_state_e     state_q;
    logic [IW-1:0] idx_q;
    logic          launch_q;
    logic          done_q;
    logic          bit_now;

    // Current exponent bit under the down-counter.
    assign bit_now = expo_i[idx_q];

    // Phase transitions, exponent index and multiplier launch pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            launch_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            done_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q  <= ST_TO_P;
                    launch_q <= 1'b1;
                end
                ST_TO_P: if (mm_done_i) begin
                    state_q  <= ST_TO_Q;
                    launch_q <= 1'b1;
                end
                ST_TO_Q: if (mm_done_i) begin
                    state_q  <= ST_SQR;
                    idx_q    <= IW'(KE - 1);
                    launch_q <= 1'b1;
                end
                ST_SQR: if (mm_done_i) begin
                    launch_q <= 1'b1;
                    if (bit_now)
                        state_q <= ST_MUL;
                    else if (idx_q == '0)
                        state_q <= ST_BACK;
                    else
                        idx_q <= idx_q - 1'b1;
                end
                ST_MUL: if (mm_done_i) begin
                    launch_q <= 1'b1;
                    if (idx_q == '0) begin
                        state_q <= ST_BACK;
                    end else begin
                        idx_q   <= idx_q - 1'b1;
                        state_q <= ST_SQR;
                    end
                end
                ST_BACK: if (mm_done_i) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register load strobes derived from phase and multiplier completion.
    always_comb begin
        latch_o    = (state_q == ST_IDLE) && start_i;
        load_p_o   = (state_q == ST_TO_P) && mm_done_i;
        load_q_o   = mm_done_i && ((state_q == ST_TO_Q) || (state_q == ST_SQR)
                                   || (state_q == ST_MUL));
        load_res_o = (state_q == ST_BACK) && mm_done_i;
    end

    assign state_o    = state_q;
    assign mm_start_o = launch_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;

    // R1: a multiply by P only ever follows a square (or continues from none else).
    a_r1_mul_after_square: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUL) && ($past(state_q) != ST_MUL) |-> ($past(state_q) == ST_SQR));

    // R4: busy follows an accepted start on the next cycle.
    a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && start_i |=> busy_o);

    // R4: busy is already low when done pulses.
    a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_o);

endmodule

// File: rtl/mod_final_sub.sv
// One conditional subtraction that maps a value in [0, 2N) into [0, N).
// Assumes the input is below 2N.
module mod_final_sub #(
    parameter int W = 32
) (
    input  logic [W:0]   x_i,
    input  logic [W-1:0] n_i,
    output logic [W-1:0] y_o
);
    logic [W:0] diff;

    // Subtract the modulus when the input reaches it.
    always_comb begin
        diff = x_i - {1'b0, n_i};
        y_o  = (x_i >= {1'b0, n_i}) ? diff[W-1:0] : x_i[W-1:0];
    end

endmodule

// File: rtl/modexp_mont.sv
// Montgomery-domain modular exponentiation: result = msg^expo mod modulus.
// Assumes modulus odd and > 1, msg < modulus, rconst = 2^(2(KW+2)) mod modulus.
// Operands are latched on an accepted start; P holds the Montgomery-form message,
// Q the running Montgomery-form accumulator.
module modexp_mont
    import modexp_pkg::*;
#(
    parameter int KW = 32,
    parameter int KE = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] msg,
    input  logic [KE-1:0] expo,
    input  logic [KW-1:0] modulus,
    input  logic [KW-1:0] rconst,
    output logic          busy,
    output logic          done,
    output logic [KW-1:0] result
);
    localparam int OPW = KW + 1;

    logic [KW-1:0]  m_r, n_r, k_r;
    logic [KE-1:0]  e_r;
    logic [OPW-1:0] p_r, q_r;
    logic [KW-1:0]  res_r;

    mx_state_e      state;
    logic           mm_start, mm_done;
    logic           latch, load_p, load_q, load_res;
    logic [OPW-1:0] op_a, op_b, mm_res, first_op;
    logic [KW-1:0]  reduced;

    modexp_seq #(.KE(KE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .expo_i     (e_r),
        .mm_done_i  (mm_done),
        .state_o    (state),
        .mm_start_o (mm_start),
        .latch_o    (latch),
        .load_p_o   (load_p),
        .load_q_o   (load_q),
        .load_res_o (load_res),
        .busy_o     (busy),
        .done_o     (done)
    );

    // Operand routing: the 2:1 mux puts P first only for the multiply step.
    always_comb begin
        first_op = (state == ST_MUL) ? p_r : q_r;
        unique case (state)
            ST_TO_P: begin op_a = {1'b0, m_r}; op_b = {1'b0, k_r}; end
            ST_TO_Q: begin op_a = {1'b0, k_r}; op_b = OPW'(1);     end
            ST_BACK: begin op_a = first_op;    op_b = OPW'(1);     end
            default: begin op_a = first_op;    op_b = q_r;         end
        endcase
    end

    mont_mul_r2 #(.W(KW)) u_mm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mm_start),
        .a_i     (op_a),
        .b_i     (op_b),
        .n_i     (n_r),
        .done_o  (mm_done),
        .res_o   (mm_res)
    );

    mod_final_sub #(.W(KW)) u_sub (
        .x_i (mm_res),
        .n_i (n_r),
        .y_o (reduced)
    );

    // Operand latches, P/Q accumulators and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_r   <= '0;
            n_r   <= '0;
            k_r   <= '0;
            e_r   <= '0;
            p_r   <= '0;
            q_r   <= '0;
            res_r <= '0;
        end else begin
            if (latch) begin
                m_r <= msg;
                n_r <= modulus;
                k_r <= rconst;
                e_r <= expo;
            end
            if (load_p)   p_r   <= mm_res;
            if (load_q)   q_r   <= mm_res;
            if (load_res) res_r <= reduced;
        end
    end

    assign result = res_r;

    // R3: the presented result is reduced below the latched modulus.
    a_r3_result_below_n: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < n_r));

    // R5: operands stay frozen while a job runs.
    a_r5_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> ($stable(n_r) && $stable(e_r) && $stable(m_r)));

endmodule

// File: tb/test_modexp_mont.sv
module test_modexp_mont;
    localparam int KW = 16;
    localparam int KE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [KW-1:0] msg = '0;
    logic [KE-1:0] expo = '0;
    logic [KW-1:0] modulus = '0;
    logic [KW-1:0] rconst = '0;
    logic          busy, done;
    logic [KW-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    modexp_mont #(.KW(KW), .KE(KE)) i_modexp_mont (
        .clk(clk), .rst_n(rst_n), .start(start), .msg(msg), .expo(expo),
        .modulus(modulus), .rconst(rconst), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned ref_pow(longint unsigned m, longint unsigned e,
                                                longint unsigned n);
        longint unsigned r = 1 % n;
        for (int i = KE - 1; i >= 0; i--) begin
            r = (r * r) % n;
            if (e[i]) r = (r * (m % n)) % n;
        end
        return r;
    endfunction

    function automatic longint unsigned ref_k(longint unsigned n);
        longint unsigned r = 1 % n;
        for (int i = 0; i < 2 * (KW + 2); i++) r = (r * 2) % n;
        return r;
    endfunction

    // Runs one job; optionally fires a second start mid-job with other operands.
    task automatic run_job(input string req, input longint unsigned m,
                           input longint unsigned e, input longint unsigned n,
                           input bit poke);
        longint unsigned want = ref_pow(m, e, n);
        int waited = 0;
        @(negedge clk);
        msg = KW'(m); expo = KE'(e); modulus = KW'(n); rconst = KW'(ref_k(n));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R4 busy after start", busy, 1);
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 60) begin
                msg = KW'(m + 1); expo = ~KE'(e); modulus = KW'(n | 3); start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        if (!done) begin
            check({req, " timeout"}, 0, 1);
        end else begin
            check({req, " result"}, result, want);
            check("R3 result below N", result < n, 1);
            check("R4 busy low at done", busy, 0);
            @(negedge clk);
            check("R4 done single cycle", done, 0);
        end
    endtask

    task automatic t_reset;
        check("R7 busy after reset", busy, 0);
        check("R7 done after reset", done, 0);
        check("R7 result after reset", result, 0);
    endtask

    task automatic t_zero_exp;
        run_job("R2 zero exponent", 1234, 0, 40961, 0);
        run_job("R2 zero exponent", 0, 0, 3, 0);
    endtask

    task automatic t_trivial_msgs;
        run_job("R6 message zero", 0, 16'h00A5, 65521, 0);
        run_job("R6 message one", 1, 16'hFFFF, 33333, 0);
    endtask

    task automatic t_all_ones;
        run_job("R1 all-ones exponent", 54321, 16'hFFFF, 65535, 0);
        run_job("R1 top bit only", 7, 16'h8000, 60001, 0);
    endtask

    task automatic t_random;
        for (int i = 0; i < 20; i++) begin
            longint unsigned n = longint'($urandom_range(3, 65535)) | 1;
            longint unsigned m = longint'($urandom) % n;
            longint unsigned e = longint'($urandom & 16'hFFFF);
            run_job("R1 random", m, e, n, 0);
        end
    endtask

    task automatic t_start_ignored;
        run_job("R5 start ignored while busy", 4321, 16'h1357, 50021, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_exp();
        t_trivial_msgs();
        t_all_ones();
        t_start_ignored();
        t_random();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule